// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog peripheral with two 16-bit registers behind a small write/read port. One register is a control word. The other is a service port that accepts keys.

Software programs an 8-bit timeout field and turns the counter on. The field counts in half-second periods, which the block receives as single-cycle pulses on a slow tick input. Software then keeps the system alive by writing a two-word key pair to the service port. Only a complete, uninterrupted pair reloads the counter from the programmed field.

When the counter runs out, the block raises a reset request for one cycle. If the output-enable bit is set, it also pulls its active-low watchdog pin low and holds it there until reset. The counter can be frozen while the chip reports low-power or debug status, each under its own suspend bit. Software can also force a reset in two ways: by writing a request bit, or by loading a zero timeout and servicing.

Top module: `kwdt_top`

## Requirements
- R1: After reset, `rst_req` is 0, `wdog_n` is 1 and the control register (address 0) reads 0x0000.
- R2: The timeout field sits in control bits [15:8]. With field value n, expiry happens on exactly the (n+1)-th counted tick after the counter is loaded; n = 0 gives one tick.
- R3: Writing 0x5555 and then 0xAAAA to address 1, while enabled and not expired, reloads the counter with the stored field plus one.
- R4: After a 0x5555 write, any other write to address 1 (0x5555 included) abandons the pair, so a following 0xAAAA does not reload.
- R5: Until enable (control bit 0) is set, ticks are not counted and service writes are ignored. The control write that sets enable loads the counter from the timeout field carried in that same write.
- R6: Enable is write-once-to-set. A control write with bit 0 clear leaves it set, and it reads back as 1.
- R7: Rewriting the timeout field while running does not change the running count; the new value is used at the next completed key pair.
- R8: While `lp_active` is 1 and control bit 1 is set, or `dbg_active` is 1 and control bit 2 is set, ticks are not counted. With the suspend bit clear, the status input has no effect.
- R9: On expiry, `rst_req` is 1 for exactly the one cycle after the expiring tick. The counter then stays stopped and later key pairs have no effect. If control bit 3 is set, `wdog_n` goes low at the same time and stays low until reset; if bit 3 is clear, `wdog_n` stays 1.
- R10: While control bit 4 is set, `wdog_n` is 0, whatever the counter state.
- R11: A control write with bit 5 set makes `rst_req` 1 in the following cycle. Bit 5 always reads back 0.
- R12: Reads at address 0 return the stored control bits (bits 7:6 and 5 read 0). Reads at address 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 control, 1 service |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tick_half | input | 1 | One-cycle pulse per half-second period |
| lp_active | input | 1 | Low-power status from the system |
| dbg_active | input | 1 | Debug-halt status from the system |
| rst_req | output | 1 | Reset request pulse |
| wdog_n | output | 1 | Active-low watchdog output pin |

## Verification
A wrong count appears at the ports as `rst_req` rising one or more ticks too early or too late. The bench sweeps the timeout field so that any off-by-one is visible on the first run. A key-sequence state machine that is left armed, or that lets a lone 0xAAAA through, shows up one tick later as a missing expiry. A lost enable or a suspend decode on the wrong bit shows up within the next few ticks as a changed expiry time or a read-back mismatch. Errors in the sticky expiry state show at `wdog_n` in the cycle after expiry and in every cycle after it.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  // control word bit positions; the bench and software decode these
  localparam int unsigned CF_EN      = 0;
  localparam int unsigned CF_SLP     = 1;
  localparam int unsigned CF_SDBG    = 2;
  localparam int unsigned CF_OE      = 3;
  localparam int unsigned CF_ASRT    = 4;
  localparam int unsigned CF_SRQ     = 5;
  localparam int unsigned CF_TMO_LSB = 8;

  // register select values
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_SVC  = 1'b1;

  typedef enum logic {
    KS_IDLE  = 1'b0,
    KS_ARMED = 1'b1
  } key_state_e;

  typedef struct packed {
    logic en;
    logic slp;
    logic sdbg;
    logic oe;
    logic asrt;
  } ctrl_flags_t;
endpackage

// File: rtl/kwdt_ctrl_reg.sv
module kwdt_ctrl_reg
  import kwdt_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TMO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output ctrl_flags_t       flags,
  output logic [TMO_W-1:0]  tmo,
  output logic [TMO_W-1:0]  tmo_new,
  output logic              enable_evt,
  output logic              swreq_evt,
  output logic [DATA_W-1:0] rd_word
);
  ctrl_flags_t      flags_q;
  logic [TMO_W-1:0] tmo_q;
  logic             unused_wdata;

  assign tmo_new      = wdata[CF_TMO_LSB +: TMO_W];
  assign enable_evt   = wr_ctrl & wdata[CF_EN] & ~flags_q.en;
  assign swreq_evt    = wr_ctrl & wdata[CF_SRQ];
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      tmo_q   <= '0;
    end else if (wr_ctrl) begin
      flags_q.en   <= flags_q.en | wdata[CF_EN];
      flags_q.slp  <= wdata[CF_SLP];
      flags_q.sdbg <= wdata[CF_SDBG];
      flags_q.oe   <= wdata[CF_OE];
      flags_q.asrt <= wdata[CF_ASRT];
      tmo_q        <= tmo_new;
    end
  end

  always_comb begin
    rd_word                      = '0;
    rd_word[CF_EN]               = flags_q.en;
    rd_word[CF_SLP]              = flags_q.slp;
    rd_word[CF_SDBG]             = flags_q.sdbg;
    rd_word[CF_OE]               = flags_q.oe;
    rd_word[CF_ASRT]             = flags_q.asrt;
    rd_word[CF_TMO_LSB +: TMO_W] = tmo_q;
  end

  assign flags = flags_q;
  assign tmo   = tmo_q;
endmodule

// File: rtl/kwdt_key_seq.sv
module kwdt_key_seq
  import kwdt_pkg::*;
#(
  parameter int unsigned        DATA_W   = 16,
  parameter logic [DATA_W-1:0]  KEY_ARM  = 16'h5555,
  parameter logic [DATA_W-1:0]  KEY_FIRE = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_svc,
  input  logic [DATA_W-1:0] wdata,
  input  logic              enabled,
  output logic              pair_done
);
  key_state_e state_q, state_d;

  function automatic key_state_e next_state(input key_state_e s,
                                            input logic [DATA_W-1:0] d);
    if (s == KS_ARMED) return KS_IDLE;
    return (d == KEY_ARM) ? KS_ARMED : KS_IDLE;
  endfunction

  always_comb begin
    state_d = state_q;
    if (!enabled)    state_d = KS_IDLE;
    else if (wr_svc) state_d = next_state(state_q, wdata);
  end

  assign pair_done = enabled & wr_svc & (state_q == KS_ARMED) & (wdata == KEY_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= KS_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/kwdt_timer.sv
module kwdt_timer #(
  parameter int unsigned TMO_W = 8,
  localparam int unsigned CNT_W = TMO_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             paused,
  input  logic             enabled,
  input  logic             load_enable,
  input  logic [TMO_W-1:0] tmo_enable,
  input  logic             load_service,
  input  logic [TMO_W-1:0] tmo_service,
  output logic [CNT_W-1:0] cnt,
  output logic             expired,
  output logic             expire_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;
  logic             step;
  logic             any_load;

  function automatic logic [CNT_W-1:0] reload_of(input logic [TMO_W-1:0] f);
    return CNT_W'(f) + CNT_W'(1);
  endfunction

  assign any_load   = load_enable | load_service;
  assign step       = tick & enabled & ~paused & ~expired_q & (cnt_q != '0) & ~any_load;
  assign expire_evt = step & (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      if (load_enable)       cnt_q <= reload_of(tmo_enable);
      else if (load_service) cnt_q <= reload_of(tmo_service);
      else if (step)         cnt_q <= cnt_q - CNT_W'(1);
      if (expire_evt) expired_q <= 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign expired = expired_q;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int unsigned       DATA_W   = 16,
  parameter int unsigned       TMO_W    = 8,
  parameter logic [DATA_W-1:0] KEY_ARM  = 16'h5555,
  parameter logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_half,
  input  logic              lp_active,
  input  logic              dbg_active,
  output logic              rst_req,
  output logic              wdog_n
);
  localparam int unsigned CNT_W = TMO_W + 1;

  // named internal events, also observed by the bound checker
  ctrl_flags_t      flags;
  logic [TMO_W-1:0] tmo_q;
  logic [TMO_W-1:0] tmo_new;
  logic             enable_evt;
  logic             swreq_evt;
  logic [DATA_W-1:0] ctrl_word;
  logic             wr_ctrl;
  logic             wr_svc;
  logic             pair_done;
  logic             service_evt;
  logic             paused;
  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;
  logic             expire_evt;
  logic             rst_req_q;

  assign wr_ctrl = bus_wr & (bus_addr == ADDR_CTRL);
  assign wr_svc  = bus_wr & (bus_addr == ADDR_SVC);

  kwdt_ctrl_reg #(.DATA_W(DATA_W), .TMO_W(TMO_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_ctrl    (wr_ctrl),
    .wdata      (bus_wdata),
    .flags      (flags),
    .tmo        (tmo_q),
    .tmo_new    (tmo_new),
    .enable_evt (enable_evt),
    .swreq_evt  (swreq_evt),
    .rd_word    (ctrl_word)
  );

  kwdt_key_seq #(.DATA_W(DATA_W), .KEY_ARM(KEY_ARM), .KEY_FIRE(KEY_FIRE)) u_keys (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_svc    (wr_svc),
    .wdata     (bus_wdata),
    .enabled   (flags.en),
    .pair_done (pair_done)
  );

  assign service_evt = pair_done & ~expired_q;
  assign paused      = (lp_active & flags.slp) | (dbg_active & flags.sdbg);

  kwdt_timer #(.TMO_W(TMO_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick_half),
    .paused       (paused),
    .enabled      (flags.en),
    .load_enable  (enable_evt),
    .tmo_enable   (tmo_new),
    .load_service (service_evt),
    .tmo_service  (tmo_q),
    .cnt          (cnt_q),
    .expired      (expired_q),
    .expire_evt   (expire_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= expire_evt | swreq_evt;
  end

  assign rst_req   = rst_req_q;
  assign wdog_n    = ~((expired_q & flags.oe) | flags.asrt);
  assign bus_rdata = (bus_addr == ADDR_CTRL) ? ctrl_word : '0;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int unsigned TMO_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = TMO_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wdog_n,
  input logic              en,
  input logic              oe,
  input logic              paused,
  input logic [TMO_W-1:0]  tmo_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              expired_q,
  input logic              expire_evt,
  input logic              service_evt
);
  assert_cnt_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !expired_q) |-> (cnt_q != '0));

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    service_evt |=> (cnt_q == CNT_W'($past(tmo_q)) + CNT_W'(1)));

  assert_no_service_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !service_evt);

  assert_enable_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  assert_suspend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && paused && !service_evt) |=> $stable(cnt_q));

  assert_single_expiry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expired_q |-> !expire_evt);

  assert_pin_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && oe) |-> !wdog_n);

  assert_svc_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr |-> (bus_rdata == '0));
endmodule

bind kwdt_top kwdt_chk #(.TMO_W(TMO_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .wdog_n      (wdog_n),
  .en          (flags.en),
  .oe          (flags.oe),
  .paused      (paused),
  .tmo_q       (tmo_q),
  .cnt_q       (cnt_q),
  .expired_q   (expired_q),
  .expire_evt  (expire_evt),
  .service_evt (service_evt)
);

// File: tb/sim_kwdt_top.sv
module sim_kwdt_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick_half = 1'b0;
  logic        lp_active = 1'b0;
  logic        dbg_active = 1'b0;
  logic        rst_req;
  logic        wdog_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kwdt_top u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tick_half  (tick_half),
    .lp_active  (lp_active),
    .dbg_active (dbg_active),
    .rst_req    (rst_req),
    .wdog_n     (wdog_n)
  );

  // control word: [15:8] timeout, 5 srq, 4 asrt, 3 oe, 2 sdbg, 1 slp, 0 en
  function automatic logic [15:0] cw(input int tmo, input bit en, input bit slp,
                                     input bit sdbg, input bit oe, input bit asrt,
                                     input bit srq);
    return {8'(tmo), 2'b00, srq, asrt, oe, sdbg, slp, en};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; tick_half = 1'b0;
    lp_active = 1'b0; dbg_active = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic service();
    wr(1'b1, 16'h5555);
    wr(1'b1, 16'hAAAA);
  endtask

  task automatic tick_once();
    tick_half = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_half = 1'b0;
  endtask

  // expect rst_req to stay low for ticks-1 ticks and rise after the last
  task automatic expect_expiry(input int ticks, input string tag);
    int early = 0;
    for (int i = 0; i < ticks - 1; i++) begin
      tick_once();
      if (rst_req) early++;
    end
    chk(early, 0, {tag, " no early expiry"});
    tick_once();
    chk(rst_req, 1'b1, {tag, " expiry on last tick"});
  endtask

  task automatic ticks_quiet(input int k, input string tag);
    int seen = 0;
    for (int i = 0; i < k; i++) begin
      tick_once();
      if (rst_req) seen++;
    end
    chk(seen, 0, tag);
  endtask

  initial begin
    int wd = 0;
    while (!done && wd < WATCHDOG_CYCLES) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(rst_req, 1'b0, "R1 rst_req");
    chk(wdog_n, 1'b1, "R1 wdog_n");
    bus_addr = 1'b0; #1;
    chk(bus_rdata, 16'h0000, "R1 ctrl readback");

    // R2 / R9 timeout sweep, alternating output enable
    for (int n = 0; n < 18; n++) begin
      int t = (n == 17) ? 255 : n;
      bit oe = (n % 2) == 0;
      do_reset();
      wr(1'b0, cw(t, 1, 0, 0, oe, 0, 0));
      expect_expiry(t + 1, "R2 sweep");
      chk(wdog_n, !oe, "R9 pin on expiry");
      @(negedge clk);
      chk(rst_req, 1'b0, "R9 single-cycle pulse");
      chk(wdog_n, !oe, "R9 pin held");
      ticks_quiet(3, "R9 counter stopped");
      service();
      chk(rst_req, 1'b0, "R9 service after expiry");
      chk(wdog_n, !oe, "R9 pin still held");
    end

    // R3 service reloads
    do_reset();
    wr(1'b0, cw(3, 1, 0, 0, 1, 0, 0));
    ticks_quiet(3, "R3 before service");
    service();
    expect_expiry(4, "R3 after service");

    // R4 broken pair: foreign word
    do_reset();
    wr(1'b0, cw(2, 1, 0, 0, 0, 0, 0));
    ticks_quiet(2, "R4 setup");
    wr(1'b1, 16'h5555); wr(1'b1, 16'h1234); wr(1'b1, 16'hAAAA);
    tick_once();
    chk(rst_req, 1'b1, "R4 foreign word breaks pair");
    // R4 broken pair: repeated arm word
    do_reset();
    wr(1'b0, cw(2, 1, 0, 0, 0, 0, 0));
    ticks_quiet(2, "R4 setup2");
    wr(1'b1, 16'h5555); wr(1'b1, 16'h5555); wr(1'b1, 16'hAAAA);
    tick_once();
    chk(rst_req, 1'b1, "R4 double arm breaks pair");
    // R4 lone fire word
    do_reset();
    wr(1'b0, cw(1, 1, 0, 0, 0, 0, 0));
    tick_once();
    wr(1'b1, 16'hAAAA);
    tick_once();
    chk(rst_req, 1'b1, "R4 lone fire ignored");

    // R5 disabled: no counting, keys ignored
    do_reset();
    wr(1'b0, cw(0, 0, 0, 0, 1, 0, 0));
    ticks_quiet(5, "R5 no count while disabled");
    chk(wdog_n, 1'b1, "R5 pin idle while disabled");
    wr(1'b1, 16'h5555);
    wr(1'b0, cw(1, 1, 0, 0, 0, 0, 0));
    tick_once();
    wr(1'b1, 16'hAAAA);
    tick_once();
    chk(rst_req, 1'b1, "R5 arm before enable ignored");

    // R6 write-once enable
    do_reset();
    wr(1'b0, cw(1, 1, 0, 0, 0, 0, 0));
    wr(1'b0, cw(1, 0, 0, 0, 0, 0, 0));
    bus_addr = 1'b0; #1;
    chk(bus_rdata, 16'h0101, "R6 enable reads back set");
    expect_expiry(2, "R6 still counting");

    // R7 timeout change applies at next service
    do_reset();
    wr(1'b0, cw(2, 1, 0, 0, 0, 0, 0));
    wr(1'b0, cw(9, 1, 0, 0, 0, 0, 0));
    expect_expiry(3, "R7 old timeout still running");
    do_reset();
    wr(1'b0, cw(3, 1, 0, 0, 0, 0, 0));
    wr(1'b0, cw(6, 1, 0, 0, 0, 0, 0));
    ticks_quiet(3, "R7 setup");
    service();
    expect_expiry(7, "R7 new timeout after service");
    // R7 forced reset: zero timeout then service
    do_reset();
    wr(1'b0, cw(10, 1, 0, 0, 0, 0, 0));
    ticks_quiet(3, "R7 setup zero");
    wr(1'b0, cw(0, 1, 0, 0, 0, 0, 0));
    service();
    expect_expiry(1, "R7 zero timeout forced");

    // R8 suspend in low power and debug
    do_reset();
    wr(1'b0, cw(1, 1, 1, 0, 0, 0, 0));
    lp_active = 1'b1;
    ticks_quiet(5, "R8 low-power hold");
    lp_active = 1'b0;
    expect_expiry(2, "R8 resume after low-power");
    do_reset();
    wr(1'b0, cw(1, 1, 0, 1, 0, 0, 0));
    dbg_active = 1'b1;
    ticks_quiet(5, "R8 debug hold");
    dbg_active = 1'b0;
    expect_expiry(2, "R8 resume after debug");
    do_reset();
    wr(1'b0, cw(1, 1, 0, 1, 0, 0, 0));
    lp_active = 1'b1;
    expect_expiry(2, "R8 low-power without suspend bit");
    lp_active = 1'b0;

    // R10 forced output assertion
    do_reset();
    wr(1'b0, cw(5, 1, 0, 0, 0, 1, 0));
    chk(wdog_n, 1'b0, "R10 pin forced low");
    chk(rst_req, 1'b0, "R10 no reset request");
    wr(1'b0, cw(5, 1, 0, 0, 0, 0, 0));
    chk(wdog_n, 1'b1, "R10 pin released");

    // R11 software reset request
    do_reset();
    wr(1'b0, cw(4, 0, 0, 0, 0, 0, 1));
    chk(rst_req, 1'b1, "R11 request pulse");
    @(negedge clk);
    chk(rst_req, 1'b0, "R11 pulse ends");
    bus_addr = 1'b0; #1;
    chk(bus_rdata, 16'h0400, "R11 request bit reads zero");

    // R12 readback of both addresses
    do_reset();
    wr(1'b0, 16'hA5DF);
    bus_addr = 1'b0; #1;
    chk(bus_rdata, 16'hA51F, "R12 control readback");
    wr(1'b1, 16'h5555);
    bus_addr = 1'b1; #1;
    chk(bus_rdata, 16'h0000, "R12 service reads zero");
    bus_addr = 1'b0;

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule